// File: doc/BRIEF.md
# Logical-to-Physical Block Remapper

This block translates logical block numbers into physical block numbers for a small flash array. Physical blocks below the logical count form the primary region; a reserved run of physical blocks above it forms the spare pool. A bad-block vector records every block known to be unusable. After reset, the host loads the factory-bad block numbers one at a time, then closes the load phase. A build pass then gives each logical block whose primary is bad a spare, before normal lookups are accepted.

At run time, a lookup returns the mapped physical block one clock after its handshake, together with a flag that says whether that physical block is bad. A program or erase failure reported against a logical block retires the physical block it maps to and swaps in the next usable spare. Spares are handed out in ascending physical order, and spares that are already bad are skipped. While a swap is in progress, both request channels are stalled. Once no usable spare remains, a sticky write-protect output rises, and only reset clears it.

Top module: `remap_l2p`

## Requirements
- R1: Out of reset, and until `init_done` is seen, `lk_ready` and `fail_ready` are low, `rsp_valid` is low and `write_protect` is low. Every logical block n starts mapped to physical block n.
- R2: A pulse on `init_mark_valid` during the load phase marks `init_mark_pblk` bad. After `init_done`, each logical block whose primary is bad receives the lowest-numbered good spare not yet used, in ascending logical order.
- R3: A lookup is accepted on a clock where `lk_valid` and `lk_ready` are both high. On the next clock, `rsp_valid` is high for exactly one cycle and `rsp_pblk` holds the mapped physical block.
- R4: `rsp_bad` is 1 exactly when the returned physical block is marked bad.
- R5: An accepted failure on a logical block with a good mapping, while a usable spare exists, marks the old physical block bad. It then maps the logical block to the lowest good unused spare, skipping spares already marked bad. The retired block is never returned again.
- R6: While a swap is in progress, `lk_ready` and `fail_ready` are low. A lookup held valid across the stall completes afterwards with the new mapping.
- R7: `write_protect` goes high once no good unused spare remains. It stays high until reset, and reset clears it.
- R8: With `write_protect` high, a failure report changes neither the mapping nor the bad flag of the block.
- R9: A failure report on a logical block whose current mapping is already bad is ignored, and no spare is consumed.
- R10: When a lookup and a failure report on the same logical block are accepted on the same clock, the lookup returns the mapping from before the failure, with `rsp_bad` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_mark_valid | input | 1 | Marks `init_mark_pblk` bad (load phase only) |
| init_mark_pblk | input | 5 | Physical block to mark bad at load |
| init_done | input | 1 | Ends the load phase and starts the build pass |
| lk_valid | input | 1 | Lookup request valid |
| lk_lblk | input | 4 | Logical block to look up |
| lk_ready | output | 1 | Lookup can be accepted |
| rsp_valid | output | 1 | Lookup result valid (one cycle) |
| rsp_pblk | output | 5 | Mapped physical block |
| rsp_bad | output | 1 | Returned physical block is bad |
| fail_valid | input | 1 | Program/erase failure report valid |
| fail_lblk | input | 4 | Logical block that failed |
| fail_ready | output | 1 | Failure report can be accepted |
| write_protect | output | 1 | Sticky: no usable spare remains |

## Verification
A wrong mapping entry, or a corrupted bad flag, shows up at the very next lookup of that logical block as a wrong `rsp_pblk` or `rsp_bad`, one cycle after the handshake. The bench therefore sweeps lookups after each build and swap. An allocation pointer that skips or repeats a spare shows up only at the next swap, as a non-ascending or duplicated physical block. A miscounted pool shows up as `write_protect` rising one swap too early or too late. Stall faults appear as a ready that is high during a swap, or as a held lookup that returns the pre-swap block.

// File: rtl/remap_pkg.sv
package remap_pkg;
   typedef enum logic [1:0] {
      ST_LOAD  = 2'd0,
      ST_BUILD = 2'd1,
      ST_SCAN  = 2'd2,
      ST_RUN   = 2'd3
   } remap_state_e;
endpackage

// File: rtl/remap_bad_table.sv
module remap_bad_table #(
   parameter int N_PHY = 24,
   localparam int PW = $clog2(N_PHY)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [PW-1:0]    set_idx,
   output logic [N_PHY-1:0] bad_vec
);
   logic [N_PHY-1:0] bad_q;

   for (genvar g = 0; g < N_PHY; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bad_q[g] <= 1'b0;
         else if (set_en && (set_idx == PW'(g)))
            bad_q[g] <= 1'b1;
      end
   end

   assign bad_vec = bad_q;
endmodule

// File: rtl/remap_map_table.sv
module remap_map_table #(
   parameter int N_LOG = 16,
   parameter int N_PHY = 24,
   localparam int LW = $clog2(N_LOG),
   localparam int PW = $clog2(N_PHY)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [LW-1:0] waddr,
   input  logic [PW-1:0] wdata,
   input  logic [LW-1:0] raddr_a,
   output logic [PW-1:0] rdata_a,
   input  logic [LW-1:0] raddr_b,
   output logic [PW-1:0] rdata_b
);
   logic [PW-1:0] map_q [N_LOG];

   for (genvar g = 0; g < N_LOG; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            map_q[g] <= PW'(g);
         else if (we && (waddr == LW'(g)))
            map_q[g] <= wdata;
      end
   end

   assign rdata_a = map_q[raddr_a];
   assign rdata_b = map_q[raddr_b];
endmodule

// File: rtl/remap_spare_pool.sv
module remap_spare_pool #(
   parameter int N_LOG          = 16,
   parameter int N_SPARE        = 8,
   parameter bit SCAN_ONE_CYCLE = 1'b0,
   localparam int N_PHY = N_LOG + N_SPARE,
   localparam int PW    = $clog2(N_PHY),
   localparam int PTRW  = $clog2(N_PHY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PHY-1:0] bad_vec,
   input  logic             step,
   output logic             cand_ok,
   output logic [PW-1:0]    cand_idx,
   output logic             none_left,
   output logic [PTRW-1:0]  ptr_o
);
   logic [PTRW-1:0] ptr_q;
   logic            any_left;

   // Any good spare at or above the allocation pointer.
   always_comb begin
      any_left = 1'b0;
      for (int j = N_LOG; j < N_PHY; j++)
         if ((PTRW'(j) >= ptr_q) && !bad_vec[j])
            any_left = 1'b1;
   end
   assign none_left = !any_left;

   if (SCAN_ONE_CYCLE) begin : g_prio
      // Priority search: the lowest good spare is found in one cycle.
      always_comb begin
         cand_ok  = 1'b0;
         cand_idx = '0;
         for (int j = N_PHY - 1; j >= N_LOG; j--)
            if ((PTRW'(j) >= ptr_q) && !bad_vec[j]) begin
               cand_ok  = 1'b1;
               cand_idx = PW'(j);
            end
      end
   end else begin : g_walk
      // Walk: one spare is examined per cycle.
      always_comb begin
         cand_ok  = 1'b0;
         cand_idx = '0;
         for (int j = N_LOG; j < N_PHY; j++)
            if (ptr_q == PTRW'(j)) begin
               cand_ok  = !bad_vec[j];
               cand_idx = PW'(j);
            end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= PTRW'(N_LOG);
      else if (step)
         ptr_q <= cand_ok ? (PTRW'(cand_idx) + PTRW'(1)) : (ptr_q + PTRW'(1));
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
   import remap_pkg::*;
#(
   parameter int N_LOG   = 16,
   parameter int N_SPARE = 8,
   localparam int N_PHY = N_LOG + N_SPARE,
   localparam int LW    = $clog2(N_LOG),
   localparam int PW    = $clog2(N_PHY)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_mark_valid,
   input  logic [PW-1:0]    init_mark_pblk,
   input  logic             init_done,
   input  logic             fail_valid,
   input  logic [LW-1:0]    fail_lblk,
   input  logic [PW-1:0]    rd_b_data,
   input  logic [N_PHY-1:0] bad_vec,
   input  logic             cand_ok,
   input  logic [PW-1:0]    cand_idx,
   input  logic             none_left,
   output logic [LW-1:0]    rd_b_addr,
   output logic             map_we,
   output logic [LW-1:0]    map_waddr,
   output logic [PW-1:0]    map_wdata,
   output logic             bad_set_en,
   output logic [PW-1:0]    bad_set_idx,
   output logic             step,
   output logic             req_ready,
   output logic             write_protect
);
   localparam logic [LW-1:0] LAST_LBLK = LW'(N_LOG - 1);

   remap_state_e state_q, state_d;
   logic [LW-1:0] bld_q, bld_d;
   logic [LW-1:0] tgt_q, tgt_d;
   logic          from_bld_q, from_bld_d;
   logic          ro_q;
   logic          cur_bad;
   logic          retire;

   assign req_ready = (state_q == ST_RUN);
   assign cur_bad   = bad_vec[rd_b_data];
   assign retire    = req_ready && fail_valid && !cur_bad && !none_left;

   always_comb begin
      unique case (state_q)
         ST_RUN:   rd_b_addr = fail_lblk;
         ST_BUILD: rd_b_addr = bld_q;
         default:  rd_b_addr = tgt_q;
      endcase
   end

   always_comb begin
      state_d     = state_q;
      bld_d       = bld_q;
      tgt_d       = tgt_q;
      from_bld_d  = from_bld_q;
      map_we      = 1'b0;
      map_waddr   = tgt_q;
      map_wdata   = cand_idx;
      bad_set_en  = 1'b0;
      bad_set_idx = init_mark_pblk;
      step        = 1'b0;
      unique case (state_q)
         ST_LOAD: begin
            bad_set_en = init_mark_valid;
            if (init_done) begin
               state_d = ST_BUILD;
               bld_d   = '0;
            end
         end
         ST_BUILD: begin
            if (cur_bad && !none_left) begin
               state_d    = ST_SCAN;
               tgt_d      = bld_q;
               from_bld_d = 1'b1;
            end else if (bld_q == LAST_LBLK) begin
               state_d = ST_RUN;
            end else begin
               bld_d = bld_q + LW'(1);
            end
         end
         ST_SCAN: begin
            step = 1'b1;
            if (cand_ok) begin
               map_we = 1'b1;
               if (!from_bld_q)
                  state_d = ST_RUN;
               else if (tgt_q == LAST_LBLK)
                  state_d = ST_RUN;
               else begin
                  state_d = ST_BUILD;
                  bld_d   = tgt_q + LW'(1);
               end
            end
         end
         ST_RUN: begin
            if (retire) begin
               bad_set_en  = 1'b1;
               bad_set_idx = rd_b_data;
               tgt_d       = fail_lblk;
               from_bld_d  = 1'b0;
               state_d     = ST_SCAN;
            end
         end
         default: state_d = ST_LOAD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_LOAD;
         bld_q      <= '0;
         tgt_q      <= '0;
         from_bld_q <= 1'b0;
         ro_q       <= 1'b0;
      end else begin
         state_q    <= state_d;
         bld_q      <= bld_d;
         tgt_q      <= tgt_d;
         from_bld_q <= from_bld_d;
         if ((state_q != ST_LOAD) && none_left)
            ro_q <= 1'b1;
      end
   end

   assign write_protect = ro_q || ((state_q != ST_LOAD) && none_left);
endmodule

// File: rtl/remap_l2p.sv
module remap_l2p #(
   parameter int N_LOG          = 16,
   parameter int N_SPARE        = 8,
   parameter bit SCAN_ONE_CYCLE = 1'b0,
   localparam int N_PHY = N_LOG + N_SPARE,
   localparam int LW    = $clog2(N_LOG),
   localparam int PW    = $clog2(N_PHY),
   localparam int PTRW  = $clog2(N_PHY + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_mark_valid,
   input  logic [PW-1:0] init_mark_pblk,
   input  logic          init_done,
   input  logic          lk_valid,
   input  logic [LW-1:0] lk_lblk,
   output logic          lk_ready,
   output logic          rsp_valid,
   output logic [PW-1:0] rsp_pblk,
   output logic          rsp_bad,
   input  logic          fail_valid,
   input  logic [LW-1:0] fail_lblk,
   output logic          fail_ready,
   output logic          write_protect
);
   if (N_LOG < 2) begin : g_cfg_log
      $error("remap_l2p: N_LOG must be at least 2");
   end
   if (N_SPARE < 1) begin : g_cfg_spare
      $error("remap_l2p: N_SPARE must be at least 1");
   end
   if ((1 << LW) != N_LOG) begin : g_cfg_pow2
      $error("remap_l2p: N_LOG must be a power of two");
   end

   logic [N_PHY-1:0] bad_vec;
   logic [PW-1:0]    rd_a_data, rd_b_data;
   logic [LW-1:0]    rd_b_addr;
   logic             map_we;
   logic [LW-1:0]    map_waddr;
   logic [PW-1:0]    map_wdata;
   logic             bad_set_en;
   logic [PW-1:0]    bad_set_idx;
   logic             step, cand_ok, none_left, req_ready;
   logic [PW-1:0]    cand_idx;
   logic [PTRW-1:0]  spare_ptr;
   logic             lk_acc;

   remap_bad_table #(.N_PHY(N_PHY)) u_bad (
      .clk(clk), .rst_n(rst_n),
      .set_en(bad_set_en), .set_idx(bad_set_idx),
      .bad_vec(bad_vec)
   );

   remap_map_table #(.N_LOG(N_LOG), .N_PHY(N_PHY)) u_map (
      .clk(clk), .rst_n(rst_n),
      .we(map_we), .waddr(map_waddr), .wdata(map_wdata),
      .raddr_a(lk_lblk), .rdata_a(rd_a_data),
      .raddr_b(rd_b_addr), .rdata_b(rd_b_data)
   );

   remap_spare_pool #(
      .N_LOG(N_LOG), .N_SPARE(N_SPARE), .SCAN_ONE_CYCLE(SCAN_ONE_CYCLE)
   ) u_pool (
      .clk(clk), .rst_n(rst_n), .bad_vec(bad_vec), .step(step),
      .cand_ok(cand_ok), .cand_idx(cand_idx),
      .none_left(none_left), .ptr_o(spare_ptr)
   );

   remap_ctrl #(.N_LOG(N_LOG), .N_SPARE(N_SPARE)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .init_mark_valid(init_mark_valid), .init_mark_pblk(init_mark_pblk),
      .init_done(init_done),
      .fail_valid(fail_valid), .fail_lblk(fail_lblk),
      .rd_b_data(rd_b_data), .bad_vec(bad_vec),
      .cand_ok(cand_ok), .cand_idx(cand_idx), .none_left(none_left),
      .rd_b_addr(rd_b_addr),
      .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata),
      .bad_set_en(bad_set_en), .bad_set_idx(bad_set_idx),
      .step(step), .req_ready(req_ready), .write_protect(write_protect)
   );

   assign lk_ready   = req_ready;
   assign fail_ready = req_ready;
   assign lk_acc     = lk_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_pblk  <= '0;
         rsp_bad   <= 1'b0;
      end else begin
         rsp_valid <= lk_acc;
         if (lk_acc) begin
            rsp_pblk <= rd_a_data;
            rsp_bad  <= bad_vec[rd_a_data];
         end
      end
   end
endmodule

// File: rtl/remap_l2p_chk.sv
module remap_l2p_chk #(
   parameter int N_LOG   = 16,
   parameter int N_SPARE = 8,
   localparam int N_PHY = N_LOG + N_SPARE,
   localparam int PW    = $clog2(N_PHY),
   localparam int PTRW  = $clog2(N_PHY + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             lk_ready,
   input logic             rsp_valid,
   input logic             write_protect,
   input logic             map_we,
   input logic [PW-1:0]    map_wdata,
   input logic [N_PHY-1:0] bad_vec,
   input logic [PTRW-1:0]  spare_ptr
);
   assert_rsp_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_ready) |=> rsp_valid);

   assert_rsp_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(lk_valid && lk_ready));

   assert_new_map_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
      map_we |-> !bad_vec[map_wdata]);

   assert_ptr_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      spare_ptr <= PTRW'(N_PHY));

   assert_ptr_moves_while_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spare_ptr) |-> !$past(lk_ready));

   assert_wp_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      write_protect |=> write_protect);

   assert_no_remap_when_protected_R8: assert property (@(posedge clk) disable iff (!rst_n)
      write_protect |-> !map_we);
endmodule

bind remap_l2p remap_l2p_chk #(.N_LOG(N_LOG), .N_SPARE(N_SPARE)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
   .rsp_valid(rsp_valid), .write_protect(write_protect),
   .map_we(map_we), .map_wdata(map_wdata), .bad_vec(bad_vec),
   .spare_ptr(spare_ptr)
);

// File: tb/remap_l2p_tb.sv
module remap_l2p_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       init_mark_valid = 1'b0;
   logic [4:0] init_mark_pblk = '0;
   logic       init_done = 1'b0;
   logic       lk_valid = 1'b0;
   logic [3:0] lk_lblk = '0;
   logic       lk_ready, rsp_valid, rsp_bad, fail_ready, write_protect;
   logic [4:0] rsp_pblk;
   logic       fail_valid = 1'b0;
   logic [3:0] fail_lblk = '0;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   remap_l2p u_dut (
      .clk(clk), .rst_n(rst_n),
      .init_mark_valid(init_mark_valid), .init_mark_pblk(init_mark_pblk),
      .init_done(init_done),
      .lk_valid(lk_valid), .lk_lblk(lk_lblk), .lk_ready(lk_ready),
      .rsp_valid(rsp_valid), .rsp_pblk(rsp_pblk), .rsp_bad(rsp_bad),
      .fail_valid(fail_valid), .fail_lblk(fail_lblk), .fail_ready(fail_ready),
      .write_protect(write_protect)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic load_and_build(input int nbad, input int list[10]);
      for (int i = 0; i < nbad; i++) begin
         init_mark_valid = 1'b1;
         init_mark_pblk  = 5'(list[i]);
         @(negedge clk);
      end
      init_mark_valid = 1'b0;
      init_done = 1'b1;
      @(negedge clk);
      init_done = 1'b0;
      while (!lk_ready) @(negedge clk);
   endtask

   task automatic lookup(input int lb, output int pb, output int bd);
      while (!lk_ready) @(negedge clk);
      lk_valid = 1'b1;
      lk_lblk  = 4'(lb);
      @(negedge clk);
      lk_valid = 1'b0;
      check("R3 rsp_valid after lookup", int'(rsp_valid), 1);
      pb = int'(rsp_pblk);
      bd = int'(rsp_bad);
   endtask

   task automatic report_fail(input int lb);
      while (!fail_ready) @(negedge clk);
      fail_valid = 1'b1;
      fail_lblk  = 4'(lb);
      @(negedge clk);
      fail_valid = 1'b0;
      while (!lk_ready) @(negedge clk);
   endtask

   // R1: reset state and identity map.
   task automatic t_reset_state();
      do_reset();
      check("R1 lk_ready low in load", int'(lk_ready), 0);
      check("R1 fail_ready low in load", int'(fail_ready), 0);
      check("R1 rsp_valid low", int'(rsp_valid), 0);
      check("R1 write_protect low", int'(write_protect), 0);
   endtask

   // R2 R3 R4 R5 R6 R7 R8 R10: one device run down to read-only.
   task automatic t_runtime_chain();
      int pb, bd;
      int bl[10] = '{3, 16, 18, 0, 0, 0, 0, 0, 0, 0};
      load_and_build(3, bl);
      for (int i = 0; i < 16; i++) begin
         lookup(i, pb, bd);
         check($sformatf("R2 build map lblk %0d", i), pb, (i == 3) ? 17 : i);
         check("R4 flag clear on good block", bd, 0);
      end
      check("R7 write_protect low with spares", int'(write_protect), 0);
      report_fail(5);
      lookup(5, pb, bd);
      check("R5 remap skips bad spare", pb, 19);
      // R10: same-cycle lookup and failure on lblk 6.
      while (!lk_ready) @(negedge clk);
      lk_valid = 1'b1; lk_lblk = 4'd6;
      fail_valid = 1'b1; fail_lblk = 4'd6;
      @(negedge clk);
      lk_valid = 1'b0; fail_valid = 1'b0;
      check("R10 same-cycle rsp_valid", int'(rsp_valid), 1);
      check("R10 same-cycle old mapping", int'(rsp_pblk), 6);
      check("R10 same-cycle flag clear", int'(rsp_bad), 0);
      check("R6 lk_ready low during swap", int'(lk_ready), 0);
      check("R6 fail_ready low during swap", int'(fail_ready), 0);
      while (!lk_ready) @(negedge clk);
      lookup(6, pb, bd);
      check("R5 remap next ascending spare", pb, 20);
      // R6: lookup held valid across a swap.
      fail_valid = 1'b1; fail_lblk = 4'd7;
      @(negedge clk);
      fail_valid = 1'b0;
      lk_valid = 1'b1; lk_lblk = 4'd7;
      begin
         int n = 0;
         while (!rsp_valid && n < 20) begin
            @(negedge clk);
            n++;
         end
         lk_valid = 1'b0;
         check("R6 held lookup completes", int'(rsp_valid), 1);
         check("R6 held lookup sees new map", int'(rsp_pblk), 21);
      end
      lookup(5, pb, bd);
      check("R5 retired block not returned", pb, 19);
      report_fail(8);
      check("R7 write_protect low with one spare", int'(write_protect), 0);
      report_fail(9);
      check("R7 write_protect high when pool empty", int'(write_protect), 1);
      lookup(9, pb, bd);
      check("R5 last spare used", pb, 23);
      report_fail(10);
      lookup(10, pb, bd);
      check("R8 mapping unchanged when protected", pb, 10);
      check("R8 bad flag unchanged when protected", bd, 0);
      check("R7 write_protect still high", int'(write_protect), 1);
   endtask

   // R9 R4 R7: pool exhausted during build, already-bad mapping ignored.
   task automatic t_build_exhaust();
      int pb, bd;
      int bl[10] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9};
      do_reset();
      check("R7 reset clears write_protect", int'(write_protect), 0);
      load_and_build(10, bl);
      check("R7 write_protect after build", int'(write_protect), 1);
      lookup(0, pb, bd);
      check("R2 first spare to lblk 0", pb, 16);
      lookup(7, pb, bd);
      check("R2 last spare to lblk 7", pb, 23);
      lookup(8, pb, bd);
      check("R4 unmapped lblk keeps primary", pb, 8);
      check("R4 flag set on bad block", bd, 1);
      report_fail(8);
      lookup(8, pb, bd);
      check("R9 already-bad report ignored", pb, 8);
      report_fail(0);
      lookup(0, pb, bd);
      check("R8 protected remap refused", pb, 16);
      check("R8 protected flag untouched", bd, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset_state();
      t_runtime_chain();
      t_build_exhaust();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule